// File: doc/BRIEF.md
# Pipelined Master Bus Requester

This block is the requesting side of a simple synchronous processor bus. A core hands it one access at a time. Each access carries an address, a read or write flag, a 2-bit size, a 2-bit access type, a 3-bit modifier and, for writes, the write data. The block registers the access and drives it onto the bus. For one cycle it pulls the active-low start strobe low. It then waits for the addressed device to pull the active-low acknowledge low, and returns the result to the core one cycle after the acknowledge edge.

A late active-low kill input changes the outcome of an access whose start cycle is running. If kill is low at the end of that cycle, the access was served by internal memory. No acknowledge is awaited and the core gets a done pulse flagged as internal. A request that is waiting at that moment is accepted on the same edge, so its start cycle follows straight on. The core sees the whole external transfer as busy. Busy drops during a start cycle in which kill is low.

Top module: `mbus_requester`

## Requirements
- R1: While reset is applied, `bus_start_n` is 1, `req_busy` is 0 and `rsp_done` is 0.
- R2: A request taken while `req_busy` is 0 appears in the next cycle: `bus_start_n` is 0 and the address, size, type and modifier outputs equal the request. `bus_rnw` is 1 for a read (`req_write`=0) and 0 for a write (`req_write`=1).
- R3: Without kill, `bus_start_n` is low for exactly one cycle per transfer and is high in the cycle after.
- R4: If `bus_kill_n` is 0 at the edge that ends the start cycle, the cycle after that edge shows `rsp_done`=1 and `rsp_internal`=1. No acknowledge is needed, and `req_busy` is 0 from then on.
- R5: During a start cycle with `bus_kill_n`=0, `req_busy` is 0. A request offered then is accepted at that edge, so `bus_start_n` is 0 again in the next cycle with the new address.
- R6: Every cycle after the start cycle in which `bus_ack_n` is 1 at the edge adds one wait state. Throughout a transfer, the address, control and write data outputs stay stable and `rsp_done` stays 0.
- R7: On a read, `rsp_rdata` takes the value `bus_rdata` had at the edge where `bus_ack_n` was 0. It shows that value together with `rsp_done`=1 and `rsp_internal`=0 in the cycle after that edge. Data present at edges without acknowledge is ignored.
- R8: On a write, `bus_wdata` equals the request's write data from the start cycle until the acknowledge edge, and a write leaves `rsp_rdata` unchanged.
- R9: `req_busy` is 1 in every cycle of an external transfer up to and including its acknowledge cycle. It is 0 once the done pulse shows.
- R10: `bus_ack_n` low during the start cycle and `bus_kill_n` low during wait states have no effect. The transfer continues until an acknowledge arrives after the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core offers an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Access address |
| req_size | input | 2 | Transfer size code |
| req_type | input | 2 | Access type code |
| req_mod | input | 3 | Access modifier code |
| req_wdata | input | 32 | Write data |
| req_busy | output | 1 | Block cannot take a request this cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_internal | output | 1 | Completed access was killed (internal) |
| rsp_rdata | output | 32 | Last read data captured |
| bus_addr | output | 32 | Bus address |
| bus_rnw | output | 1 | 1 = read, 0 = write |
| bus_size | output | 2 | Bus transfer size |
| bus_type | output | 2 | Bus access type |
| bus_mod | output | 3 | Bus access modifier |
| bus_wdata | output | 32 | Bus write data |
| bus_start_n | output | 1 | Transfer start strobe, active low |
| bus_kill_n | input | 1 | Late kill, active low, sampled at end of start cycle |
| bus_ack_n | input | 1 | Transfer acknowledge, active low |
| bus_rdata | input | 32 | Bus read data |

## Verification
The start strobe and the registered request fields appear one cycle after the accepting edge. `req_busy` reacts to kill within the same cycle. After an acknowledge edge or a kill edge, the done pulse, the internal flag and the captured read data appear exactly one cycle later. The bench drives every input just after a falling edge and reads outputs at the following falling edge. Each expected value is therefore checked in the cycle that the register count predicts. The sweep walks wait counts 0 to 3 across every size code and both directions, with stray acknowledge and kill pulses placed in the start cycle and the wait cycles. It also covers killed accesses and a killed access followed directly by a new one.

// File: rtl/mbreq_pkg.sv
package mbreq_pkg;
    localparam int SIZE_W = 2;
    localparam int TYPE_W = 2;
    localparam int MOD_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2
    } mbreq_state_e;
endpackage

// File: rtl/mbreq_ctrl.sv
module mbreq_ctrl
    import mbreq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [TYPE_W-1:0] req_type,
    input  logic [MOD_W-1:0]  req_mod,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_busy,
    input  logic              bus_kill_n,
    input  logic              bus_ack_n,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_rnw,
    output logic [SIZE_W-1:0] bus_size,
    output logic [TYPE_W-1:0] bus_type,
    output logic [MOD_W-1:0]  bus_mod,
    output logic [DW-1:0]     bus_wdata,
    output logic              bus_start_n,
    output logic              evt_kill,
    output logic              evt_ack,
    output logic              evt_rd
);

    typedef struct packed {
        mbreq_state_e      state;
        logic [AW-1:0]     addr;
        logic              rnw;
        logic [SIZE_W-1:0] size;
        logic [TYPE_W-1:0] ttype;
        logic [MOD_W-1:0]  tmod;
        logic [DW-1:0]     wdata;
        logic              start_n;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  accept;

    always_comb begin
        r_d      = r_q;
        evt_kill = (r_q.state == ST_START) && !bus_kill_n;
        evt_ack  = (r_q.state == ST_WAIT) && !bus_ack_n;
        evt_rd   = evt_ack && r_q.rnw;
        req_busy = (r_q.state == ST_WAIT) || ((r_q.state == ST_START) && bus_kill_n);
        accept   = req_valid && !req_busy;

        r_d.start_n = 1'b1;
        unique case (r_q.state)
            ST_IDLE:  r_d.state = ST_IDLE;
            ST_START: r_d.state = evt_kill ? ST_IDLE : ST_WAIT;
            ST_WAIT:  r_d.state = evt_ack ? ST_IDLE : ST_WAIT;
            default:  r_d.state = ST_IDLE;
        endcase

        if (accept) begin
            r_d.state   = ST_START;
            r_d.start_n = 1'b0;
            r_d.addr    = req_addr;
            r_d.rnw     = !req_write;
            r_d.size    = req_size;
            r_d.ttype   = req_type;
            r_d.tmod    = req_mod;
            r_d.wdata   = req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.state   <= ST_IDLE;
            r_q.rnw     <= 1'b1;
            r_q.start_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_addr    = r_q.addr;
    assign bus_rnw     = r_q.rnw;
    assign bus_size    = r_q.size;
    assign bus_type    = r_q.ttype;
    assign bus_mod     = r_q.tmod;
    assign bus_wdata   = r_q.wdata;
    assign bus_start_n = r_q.start_n;

    assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_busy) |=> (!bus_start_n && bus_addr == $past(req_addr)));

    assert_start_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_start_n && bus_kill_n) |=> bus_start_n);

    assert_wait_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_WAIT) && bus_ack_n) |=>
            ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_rnw) && r_q.state == ST_WAIT));

    assert_busy_in_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT) |-> req_busy);

endmodule

// File: rtl/mbreq_resp.sv
module mbreq_resp #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_kill,
    input  logic          evt_ack,
    input  logic          evt_rd,
    input  logic [DW-1:0] bus_rdata,
    output logic          rsp_done,
    output logic          rsp_internal,
    output logic [DW-1:0] rsp_rdata
);

    typedef struct packed {
        logic          done;
        logic          internal;
        logic [DW-1:0] rdata;
    } resp_t;

    resp_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.done     = evt_kill || evt_ack;
        s_d.internal = evt_kill;
        if (evt_rd) begin
            s_d.rdata = bus_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_done     = s_q.done;
    assign rsp_internal = s_q.internal;
    assign rsp_rdata    = s_q.rdata;

    assert_kill_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_kill |=> (rsp_done && rsp_internal));

    assert_read_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rd |=> (rsp_done && !rsp_internal && rsp_rdata == $past(bus_rdata)));

endmodule

// File: rtl/mbus_requester.sv
module mbus_requester
    import mbreq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [TYPE_W-1:0] req_type,
    input  logic [MOD_W-1:0]  req_mod,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_busy,
    output logic              rsp_done,
    output logic              rsp_internal,
    output logic [DW-1:0]     rsp_rdata,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_rnw,
    output logic [SIZE_W-1:0] bus_size,
    output logic [TYPE_W-1:0] bus_type,
    output logic [MOD_W-1:0]  bus_mod,
    output logic [DW-1:0]     bus_wdata,
    output logic              bus_start_n,
    input  logic              bus_kill_n,
    input  logic              bus_ack_n,
    input  logic [DW-1:0]     bus_rdata
);

    logic evt_kill, evt_ack, evt_rd;

    mbreq_ctrl #(.AW(AW), .DW(DW)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_type    (req_type),
        .req_mod     (req_mod),
        .req_wdata   (req_wdata),
        .req_busy    (req_busy),
        .bus_kill_n  (bus_kill_n),
        .bus_ack_n   (bus_ack_n),
        .bus_addr    (bus_addr),
        .bus_rnw     (bus_rnw),
        .bus_size    (bus_size),
        .bus_type    (bus_type),
        .bus_mod     (bus_mod),
        .bus_wdata   (bus_wdata),
        .bus_start_n (bus_start_n),
        .evt_kill    (evt_kill),
        .evt_ack     (evt_ack),
        .evt_rd      (evt_rd)
    );

    mbreq_resp #(.DW(DW)) resp_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_kill     (evt_kill),
        .evt_ack      (evt_ack),
        .evt_rd       (evt_rd),
        .bus_rdata    (bus_rdata),
        .rsp_done     (rsp_done),
        .rsp_internal (rsp_internal),
        .rsp_rdata    (rsp_rdata)
    );

endmodule

// File: tb/mbus_requester_tb_top.sv
module mbus_requester_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_size = '0, req_type = '0;
    logic [2:0]  req_mod = '0;
    logic        req_busy, rsp_done, rsp_internal;
    logic [31:0] rsp_rdata, bus_addr, bus_wdata;
    logic        bus_rnw, bus_start_n;
    logic [1:0]  bus_size, bus_type;
    logic [2:0]  bus_mod;
    logic        bus_kill_n = 1'b1, bus_ack_n = 1'b1;
    logic [31:0] bus_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_rd = '0;

    always #5 clk = ~clk;

    mbus_requester dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_type(req_type), .req_mod(req_mod),
        .req_wdata(req_wdata), .req_busy(req_busy),
        .rsp_done(rsp_done), .rsp_internal(rsp_internal), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_rnw(bus_rnw), .bus_size(bus_size),
        .bus_type(bus_type), .bus_mod(bus_mod), .bus_wdata(bus_wdata),
        .bus_start_n(bus_start_n), .bus_kill_n(bus_kill_n),
        .bus_ack_n(bus_ack_n), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic offer(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                         input logic [1:0] tp, input logic [2:0] md, input logic [31:0] wd);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
        req_type = tp; req_mod = md; req_wdata = wd;
    endtask

    task automatic check_fields(input string tag, input bit wr, input logic [31:0] a,
                                input logic [1:0] sz, input logic [1:0] tp,
                                input logic [2:0] md, input logic [31:0] wd);
        chk({tag, " addr"}, 64'(bus_addr), 64'(a));
        chk({tag, " rnw"}, 64'(bus_rnw), 64'(!wr));
        chk({tag, " size/type/mod"}, 64'({bus_size, bus_type, bus_mod}), 64'({sz, tp, md}));
        if (wr) chk("R8 wdata", 64'(bus_wdata), 64'(wd));
    endtask

    // called just after a falling edge with the block idle
    task automatic xfer(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic [1:0] tp, input logic [2:0] md, input logic [31:0] wd,
                        input logic [31:0] rd, input int waits, input bit kill, input bit noise);
        chk("R9 idle busy", 64'(req_busy), 64'(0));
        offer(wr, a, sz, tp, md, wd);
        @(negedge clk);
        chk("R2 start low", 64'(bus_start_n), 64'(0));
        chk("R4 done pulse ends", 64'(rsp_done), 64'(0));
        check_fields("R2", wr, a, sz, tp, md, wd);
        req_valid  = 1'b0;
        bus_kill_n = !kill;
        bus_ack_n  = !noise;          // R10: ack during start cycle must be ignored
        bus_rdata  = ~rd;
        #1;
        chk("R5 busy with kill", 64'(req_busy), 64'(!kill));
        if (kill) begin
            @(negedge clk);
            bus_kill_n = 1'b1; bus_ack_n = 1'b1;
            chk("R4 done", 64'(rsp_done), 64'(1));
            chk("R4 internal", 64'(rsp_internal), 64'(1));
            chk("R4 busy", 64'(req_busy), 64'(0));
            chk("R3 start high", 64'(bus_start_n), 64'(1));
            chk("R4 rdata kept", 64'(rsp_rdata), 64'(exp_rd));
        end else begin
            for (int w = 0; w <= waits; w++) begin
                @(negedge clk);
                bus_kill_n = !noise;  // R10: kill during wait must be ignored
                chk("R3 start high", 64'(bus_start_n), 64'(1));
                chk("R9 busy", 64'(req_busy), 64'(1));
                chk("R6 no done", 64'(rsp_done), 64'(0));
                check_fields("R6", wr, a, sz, tp, md, wd);
                bus_ack_n = (w == waits) ? 1'b0 : 1'b1;
                bus_rdata = (w == waits) ? rd : (rd ^ 32'(w + 1));
            end
            @(negedge clk);
            bus_ack_n = 1'b1; bus_kill_n = 1'b1;
            chk("R7 done", 64'(rsp_done), 64'(1));
            chk("R7 not internal", 64'(rsp_internal), 64'(0));
            chk("R9 busy cleared", 64'(req_busy), 64'(0));
            if (!wr) exp_rd = rd;
            chk(wr ? "R8 rdata kept" : "R7 rdata", 64'(rsp_rdata), 64'(exp_rd));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 start_n", 64'(bus_start_n), 64'(1));
        chk("R1 busy", 64'(req_busy), 64'(0));
        chk("R1 done", 64'(rsp_done), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        for (int wr = 0; wr < 2; wr++)
            for (int waits = 0; waits < 4; waits++)
                for (int sz = 0; sz < 4; sz++)
                    xfer(wr[0], 32'h1000_0000 + 32'(wr * 256 + waits * 16 + sz * 4),
                         2'(sz), 2'(waits), 3'(sz + waits), 32'hA5A5_0000 + 32'(waits * 4 + sz),
                         32'h5A00_0000 + 32'(wr * 64 + waits * 8 + sz), waits,
                         1'b0, ((waits + sz) % 2) == 1);

        for (int sz = 0; sz < 4; sz++)
            xfer(sz[0], 32'h2000_0000 + 32'(sz), 2'(sz), 2'(sz), 3'(sz), 32'h0BAD_0000 + 32'(sz),
                 32'hDEAD_0000, 0, 1'b1, sz[1]);

        // R5: killed access followed straight on by a new read
        offer(1'b0, 32'h3000_0000, 2'd2, 2'd1, 3'd5, 32'h0);
        @(negedge clk);
        chk("R5 first start", 64'(bus_start_n), 64'(0));
        bus_kill_n = 1'b0;
        offer(1'b0, 32'h3000_0040, 2'd1, 2'd3, 3'd2, 32'h0);
        #1;
        chk("R5 busy drops on kill", 64'(req_busy), 64'(0));
        @(negedge clk);
        bus_kill_n = 1'b1; req_valid = 1'b0;
        chk("R5 back-to-back start", 64'(bus_start_n), 64'(0));
        check_fields("R5", 1'b0, 32'h3000_0040, 2'd1, 2'd3, 3'd2, 32'h0);
        chk("R5 internal done", 64'({rsp_done, rsp_internal}), 64'(2'b11));
        bus_ack_n = 1'b1;
        @(negedge clk);
        bus_ack_n = 1'b0; bus_rdata = 32'hC0FF_EE01;
        @(negedge clk);
        bus_ack_n = 1'b1;
        chk("R5 second done", 64'({rsp_done, rsp_internal}), 64'(2'b10));
        chk("R7 second rdata", 64'(rsp_rdata), 64'(32'hC0FF_EE01));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule